// File: doc/BRIEF.md
# EDID Register-Mapped I2C Responder

This block models a display I2C controller at register level. It only serves reads of a monitor's identification data (EDID) from the standard 7-bit target address 0x50. No wire-level I2C signalling takes place. The host selects a port, writes a command word and then pulls EDID bytes from a data register, up to four bytes per read. Each step of the transfer is a side effect of these register accesses. The status bits and the bus phase (idle, data, wait) advance in response.

Each port has its own EDID memory, loaded through a side port. Two input vectors say, for each port, whether a monitor is attached and whether it is a DisplayPort sink. The block answers EDID requests only for present monitors that are not DisplayPort sinks. A session holds the selected target, the EDID-available flag, the byte pointer, the transfer length and the cycle type. The session is cleared by a port-select write, by a qualifying stop, or by the read that delivers the final bytes of a transfer.

Top module: `edid_i2c_regs`

## Requirements
- R1: After reset every register, every status bit and the read data are zero, and the phase is idle. A host read (req_i high, we_i low) presents the register on rdata_o with rvalid_o high one clock after the request.
- R2: Register index 2 is status. Its bits are ready at 0, error at 1, active at 2, wait flag at 3, phase at 5:4 (0 idle, 1 data, 2 wait) and in-use at 6. A status read returns the value held before the read and then sets in-use. A status write with bit 6 set clears in-use, and every other status bit ignores writes.
- R3: Register index 0 is port select. Any write to it stores the word, clears the session and forces the phase to idle. A low 3-bit value of 1 to 4 selects port value−1. It also sets ready and the wait flag and clears active. It clears error when a monitor is present on that port and the port is not DisplayPort, and sets error otherwise. The values 0, 5, 6 and 7 change no status bit.
- R4: Register index 1 is command. Bits 7:1 are the target address, bit 0 is the read direction, bits 15:8 are the start index, bits 24:16 are the byte count and bits 27:25 are the cycle code. An address of 0x50 selects the target. Any other address leaves the selection as it was. With no target selected, data reads deliver zero bytes.
- R5: Cycle codes 1, 3, 5 and 7 set the phase to data and set active. Codes 2 and 6 change neither. Bit 26 set loads the pointer from the start index.
- R6: Cycle code 4 (stop) clears the session, sets the phase to idle and clears active. It does so only when the previously stored command held a nonzero cycle code.
- R7: Register index 3 is data. When command bit 0 is set and the count exceeds the pointer, a data read replaces the lowest min(4, count−pointer) bytes of the latched word with EDID bytes, lowest lane first. The upper bytes keep their old value, and the pointer advances. Otherwise the read returns the latched word unchanged. Writes to data are ignored.
- R8: A data read with at most four bytes left clears the session. It sets the phase to idle when cycle-code bit 27 is set and to wait otherwise. Active is left as it was.
- R9: A byte whose address is 128 or more, or that is read with no target selected or no EDID available, reads as zero and does not advance the pointer.
- R10: Bit 30 of a stored command always reads back as 0. Writing bit 31 as 1 while the stored bit 31 is 0 sets ready. While the stored bit 31 is 1, a command write with bit 31 clear only clears stored bit 31. It also sets status to ready alone, plus error when no EDID is available, and sets the phase to idle. A command write with bit 31 set is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host access request, one cycle |
| we_i | input | 1 | Host access is a write |
| addr_i | input | 2 | Register index: 0 port select, 1 command, 2 status, 3 data |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| ld_we_i | input | 1 | EDID memory load strobe |
| ld_port_i | input | 2 | Port whose EDID memory is loaded |
| ld_addr_i | input | 7 | EDID byte address to load |
| ld_data_i | input | 8 | EDID byte to load |
| mon_present_i | input | 4 | Per-port monitor attached flag |
| port_is_dp_i | input | 4 | Per-port DisplayPort sink flag |

## Verification
The hardest state to reach is a transfer whose window crosses the end of EDID memory. Here the count exceeds the bytes that remain, so one read mixes real bytes with zero lanes and the next read returns only zeros. The stimulus loads the pointer with an index of 126 and requests 132 bytes. A second hard case is a stop that must not act. To reach it, a command with cycle code 0 is stored first, so the stop that follows is inert, and a data read then shows that the session survived. A third is the lane merge on a short final read: a six-byte transfer ends on a two-byte read, and that read must keep the upper half of the previous word.

// File: rtl/edid_pkg.sv
package edid_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;

  localparam logic [1:0] REG_PSEL = 2'd0;
  localparam logic [1:0] REG_CMD  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  // command word fields
  localparam int CMD_DIR_BIT   = 0;
  localparam int CMD_IDXEN_BIT = 26;
  localparam int CMD_SWRDY_BIT = 30;
  localparam int CMD_CLRI_BIT  = 31;

  localparam logic [2:0] CYC_NONE = 3'd0;
  localparam logic [2:0] CYC_STOP = 3'd4;

  // status bit positions
  localparam int ST_RDY   = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_ACT   = 2;
  localparam int ST_WAIT  = 3;
  localparam int ST_INUSE = 6;

endpackage

// File: rtl/edid_store.sv
module edid_store
  import edid_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int EDID_BYTES = 128,
  parameter int PW         = 2,
  parameter int AW         = 7
) (
  input  logic                  clk_i,
  input  logic                  ld_we_i,
  input  logic [PW-1:0]         ld_port_i,
  input  logic [AW-1:0]         ld_addr_i,
  input  logic [7:0]            ld_data_i,
  input  logic [PW-1:0]         rd_port_i,
  input  logic [7:0]            rd_base_i,
  output logic [LANES-1:0][7:0] rd_byte_o
);

  localparam int         DEPTH = NUM_PORTS * EDID_BYTES;
  localparam logic [8:0] LIMIT = 9'(EDID_BYTES);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (ld_we_i) mem_q[{ld_port_i, ld_addr_i}] <= ld_data_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [8:0] a;
    assign a            = {1'b0, rd_base_i} + 9'(l);
    assign rd_byte_o[l] = (a < LIMIT) ? mem_q[{rd_port_i, a[AW-1:0]}] : 8'h00;
  end

endmodule

// File: rtl/edid_fetch.sv
module edid_fetch
  import edid_pkg::*;
#(
  parameter int EDID_BYTES = 128
) (
  input  logic                  tgt_i,
  input  logic                  avail_i,
  input  logic [7:0]            ptr_i,
  input  logic [8:0]            total_i,
  input  logic [LANES-1:0][7:0] mem_byte_i,
  input  logic [LANES*8-1:0]    prev_i,
  output logic                  has_left_o,
  output logic                  last_o,
  output logic [2:0]            adv_o,
  output logic [LANES*8-1:0]    word_o
);

  localparam logic [8:0]        LIMIT  = 9'(EDID_BYTES);
  localparam logic signed [9:0] LANE_S = 10'(LANES);

  logic signed [9:0] left;
  logic [2:0]        n;
  logic [LANES-1:0]  ok;

  assign left       = $signed({1'b0, total_i}) - $signed({2'b00, ptr_i});
  assign has_left_o = left > 10'sd0;
  assign last_o     = left <= LANE_S;
  assign n          = (left >= LANE_S) ? 3'(LANES) : left[2:0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic on;
    assign on    = 3'(l) < n;
    // once a lane falls off the end, later lanes do too: pointer stalls there
    assign ok[l] = on && tgt_i && avail_i && (({1'b0, ptr_i} + 9'(l)) < LIMIT);
    assign word_o[l*8 +: 8] = on ? (ok[l] ? mem_byte_i[l] : 8'h00) : prev_i[l*8 +: 8];
  end

  assign adv_o = 3'($countones(ok));

endmodule

// File: rtl/edid_i2c_regs.sv
module edid_i2c_regs
  import edid_pkg::*;
#(
  parameter int         NUM_PORTS  = 4,
  parameter int         EDID_BYTES = 128,
  parameter logic [6:0] TGT_ADDR   = 7'h50
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [1:0]           addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic                 rvalid_o,
  input  logic                 ld_we_i,
  input  logic [1:0]           ld_port_i,
  input  logic [6:0]           ld_addr_i,
  input  logic [7:0]           ld_data_i,
  input  logic [NUM_PORTS-1:0] mon_present_i,
  input  logic [NUM_PORTS-1:0] port_is_dp_i
);

  localparam int         PW      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int         AW      = $clog2(EDID_BYTES);
  localparam int         DW      = LANES * 8;
  localparam logic [2:0] MAX_SEL = 3'(NUM_PORTS);

  // registers
  logic [31:0]   psel_q, cmd_q, data_q;
  phase_e        phase_q;
  logic          rdy_q, err_q, act_q, wflag_q, inuse_q;
  // session
  logic          tgt_q, avail_q;
  logic [7:0]    ptr_q;
  logic [8:0]    total_q;
  logic [2:0]    cyc_q;
  logic [PW-1:0] port_q;

  logic [31:0] stat_word;
  assign stat_word = {25'd0, inuse_q, phase_q, wflag_q, act_q, err_q, rdy_q};

  logic wr_psel, wr_cmd, wr_stat, rd_any, rd_stat, rd_data;
  assign wr_psel = req_i && we_i && (addr_i == REG_PSEL);
  assign wr_cmd  = req_i && we_i && (addr_i == REG_CMD);
  assign wr_stat = req_i && we_i && (addr_i == REG_STAT);
  assign rd_any  = req_i && !we_i;
  assign rd_stat = rd_any && (addr_i == REG_STAT);
  assign rd_data = rd_any && (addr_i == REG_DATA);

  logic [2:0]    sel, sel_m1;
  logic [PW-1:0] sel_idx;
  logic          sel_ok;
  assign sel     = wdata_i[2:0];
  assign sel_m1  = sel - 3'd1;
  assign sel_idx = sel_m1[PW-1:0];
  assign sel_ok  = (sel != 3'd0) && (sel <= MAX_SEL);

  logic [31:0] cmd_w;
  logic [2:0]  cyc_w;
  assign cmd_w = wdata_i & ~(32'd1 << CMD_SWRDY_BIT);
  assign cyc_w = cmd_w[27:25];

  logic [LANES-1:0][7:0] mem_byte;
  logic                  has_left, last;
  logic [2:0]            adv;
  logic [DW-1:0]         merged;
  logic                  fire;

  edid_store #(
    .NUM_PORTS (NUM_PORTS),
    .EDID_BYTES(EDID_BYTES),
    .PW        (PW),
    .AW        (AW)
  ) i_store (
    .clk_i     (clk_i),
    .ld_we_i   (ld_we_i),
    .ld_port_i (ld_port_i[PW-1:0]),
    .ld_addr_i (ld_addr_i[AW-1:0]),
    .ld_data_i (ld_data_i),
    .rd_port_i (port_q),
    .rd_base_i (ptr_q),
    .rd_byte_o (mem_byte)
  );

  edid_fetch #(
    .EDID_BYTES(EDID_BYTES)
  ) i_fetch (
    .tgt_i     (tgt_q),
    .avail_i   (avail_q),
    .ptr_i     (ptr_q),
    .total_i   (total_q),
    .mem_byte_i(mem_byte),
    .prev_i    (data_q),
    .has_left_o(has_left),
    .last_o    (last),
    .adv_o     (adv),
    .word_o    (merged)
  );

  assign fire = rd_data && cmd_q[CMD_DIR_BIT] && has_left;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psel_q   <= '0;
      cmd_q    <= '0;
      data_q   <= '0;
      phase_q  <= PH_IDLE;
      rdy_q    <= 1'b0;
      err_q    <= 1'b0;
      act_q    <= 1'b0;
      wflag_q  <= 1'b0;
      inuse_q  <= 1'b0;
      tgt_q    <= 1'b0;
      avail_q  <= 1'b0;
      ptr_q    <= '0;
      total_q  <= '0;
      cyc_q    <= '0;
      port_q   <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_any;
      if (rd_any) begin
        case (addr_i)
          REG_PSEL: rdata_o <= psel_q;
          REG_CMD:  rdata_o <= cmd_q;
          REG_STAT: rdata_o <= stat_word;
          default:  rdata_o <= fire ? merged : data_q;
        endcase
      end

      if (rd_stat) inuse_q <= 1'b1;

      if (fire) begin
        data_q <= merged;
        ptr_q  <= ptr_q + 8'(adv);
        if (last) begin
          phase_q <= cyc_q[2] ? PH_IDLE : PH_WAIT;
          tgt_q   <= 1'b0;
          avail_q <= 1'b0;
          ptr_q   <= '0;
          total_q <= '0;
          cyc_q   <= '0;
        end
      end

      if (wr_stat && wdata_i[ST_INUSE]) inuse_q <= 1'b0;

      if (wr_psel) begin
        psel_q  <= wdata_i;
        phase_q <= PH_IDLE;
        tgt_q   <= 1'b0;
        avail_q <= 1'b0;
        ptr_q   <= '0;
        total_q <= '0;
        cyc_q   <= '0;
        if (sel_ok) begin
          port_q  <= sel_idx;
          rdy_q   <= 1'b1;
          wflag_q <= 1'b1;
          act_q   <= 1'b0;
          if (mon_present_i[sel_idx] && !port_is_dp_i[sel_idx]) begin
            avail_q <= 1'b1;
            err_q   <= 1'b0;
          end else begin
            err_q   <= 1'b1;
          end
        end
      end

      if (wr_cmd) begin
        if (cmd_q[CMD_CLRI_BIT]) begin
          if (!wdata_i[CMD_CLRI_BIT]) begin
            cmd_q[CMD_CLRI_BIT] <= 1'b0;
            rdy_q   <= 1'b1;
            err_q   <= !avail_q;
            act_q   <= 1'b0;
            wflag_q <= 1'b0;
            inuse_q <= 1'b0;
            phase_q <= PH_IDLE;
          end
        end else begin
          if (cmd_w[CMD_CLRI_BIT]) rdy_q <= 1'b1;
          total_q <= cmd_w[24:16];
          if (cmd_w[7:1] == TGT_ADDR) tgt_q <= 1'b1;
          if (cmd_w[CMD_IDXEN_BIT]) ptr_q <= cmd_w[15:8];
          cyc_q <= cyc_w;
          case (cyc_w)
            CYC_STOP: begin
              if (cmd_q[27:25] != CYC_NONE) begin
                tgt_q   <= 1'b0;
                avail_q <= 1'b0;
                ptr_q   <= '0;
                total_q <= '0;
                cyc_q   <= '0;
                phase_q <= PH_IDLE;
                act_q   <= 1'b0;
              end
            end
            3'd1, 3'd3, 3'd5, 3'd7: begin
              phase_q <= PH_DATA;
              act_q   <= 1'b1;
            end
            default: ;
          endcase
          cmd_q <= cmd_w;
        end
      end
    end
  end

  // R2: a status read leaves in-use set
  p_inuse_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |=> inuse_q);

  // R3: a mapped port select leaves ready set, active clear, phase idle
  p_psel_map_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_psel && sel_ok) |=> (rdy_q && !act_q && phase_q == PH_IDLE));

  // R6: a qualified stop idles the bus
  p_stop_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && !cmd_q[CMD_CLRI_BIT] && cyc_w == CYC_STOP && cmd_q[27:25] != CYC_NONE)
      |=> (phase_q == PH_IDLE && !act_q && !tgt_q));

  // R7: data writes touch neither latch nor pointer
  p_data_wr_ign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == REG_DATA) |=> ($stable(data_q) && $stable(ptr_q)));

  // R9: no target, no pointer movement
  p_no_tgt_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !tgt_q && !last) |=> $stable(ptr_q));

  // R10: software-ready never stored
  p_swrdy_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd |=> !cmd_q[CMD_SWRDY_BIT]);

endmodule

// File: tb/test_edid_i2c_regs.sv
module test_edid_i2c_regs;

  typedef struct packed {
    logic        wr;
    logic [1:0]  rg;
    logic [31:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam logic [1:0] PS = 2'd0, CM = 2'd1, ST = 2'd2, DT = 2'd3;
  localparam int NV = 60;

  // EDID byte at port p, address a is (a + 0x40*p) mod 256; port 0 holds a itself
  localparam vec_t VECS [NV] = '{
    '{1'b0, ST, 32'h0000_0000, 4'd1},  // R1 reset status
    '{1'b0, ST, 32'h0000_0040, 4'd2},  // R2 in-use after read
    '{1'b1, ST, 32'h0000_0040, 4'd2},
    '{1'b0, ST, 32'h0000_0000, 4'd2},  // R2 cleared
    '{1'b1, ST, 32'hFFFF_FFBF, 4'd2},
    '{1'b0, ST, 32'h0000_0040, 4'd2},  // R2 other bits read-only
    '{1'b1, ST, 32'h0000_0040, 4'd2},
    '{1'b1, CM, 32'h8000_0000, 4'd10},
    '{1'b0, ST, 32'h0000_0001, 4'd10}, // R10 ready set
    '{1'b1, CM, 32'h0000_0000, 4'd10},
    '{1'b0, ST, 32'h0000_0003, 4'd10}, // R10 ready + error, no EDID
    '{1'b0, CM, 32'h0000_0000, 4'd10},
    '{1'b1, PS, 32'h0000_0001, 4'd3},
    '{1'b0, ST, 32'h0000_0049, 4'd3},  // R3 port 0 good
    '{1'b1, CM, 32'h0E0A_02A1, 4'd5},
    '{1'b0, ST, 32'h0000_005D, 4'd5},  // R5 data phase, active
    '{1'b0, DT, 32'h0504_0302, 4'd7},
    '{1'b0, DT, 32'h0908_0706, 4'd7},
    '{1'b0, DT, 32'h0908_0706, 4'd7},  // R7 nothing left
    '{1'b0, ST, 32'h0000_004D, 4'd8},  // R8 stop type -> idle
    '{1'b1, PS, 32'h0000_0001, 4'd3},
    '{1'b1, CM, 32'h0206_00A1, 4'd5},
    '{1'b0, DT, 32'h0302_0100, 4'd7},
    '{1'b0, DT, 32'h0302_0504, 4'd7},  // R7 upper lanes kept
    '{1'b0, ST, 32'h0000_006D, 4'd8},  // R8 wait phase
    '{1'b1, DT, 32'hDEAD_BEEF, 4'd7},
    '{1'b1, CM, 32'h0800_0000, 4'd6},
    '{1'b0, ST, 32'h0000_0049, 4'd6},  // R6 stop acted
    '{1'b0, DT, 32'h0302_0504, 4'd7},  // R7 write ignored, dir bit clear
    '{1'b1, PS, 32'h0000_0001, 4'd3},
    '{1'b1, CM, 32'h0004_00A1, 4'd4},
    '{1'b1, CM, 32'h0804_0001, 4'd6},
    '{1'b0, DT, 32'h0302_0100, 4'd6},  // R6 stop after code 0 inert
    '{1'b0, ST, 32'h0000_0049, 4'd8},
    '{1'b1, PS, 32'h0000_0001, 4'd3},
    '{1'b1, CM, 32'h0A04_00C1, 4'd4},
    '{1'b0, DT, 32'h0000_0000, 4'd4},  // R4 foreign address -> zeros
    '{1'b0, ST, 32'h0000_004D, 4'd8},
    '{1'b1, PS, 32'h0000_0004, 4'd3},
    '{1'b0, ST, 32'h0000_004B, 4'd3},  // R3 DP sink -> error
    '{1'b1, PS, 32'h0000_0001, 4'd3},
    '{1'b0, ST, 32'h0000_0049, 4'd3},
    '{1'b1, PS, 32'h0000_0003, 4'd3},
    '{1'b0, ST, 32'h0000_004B, 4'd3},  // R3 absent monitor -> error
    '{1'b1, PS, 32'h0000_0001, 4'd3},
    '{1'b1, CM, 32'h0404_00A1, 4'd5},
    '{1'b0, ST, 32'h0000_0049, 4'd5},  // R5 reserved code inert
    '{1'b1, CM, 32'h0684_7EA1, 4'd9},
    '{1'b0, DT, 32'h0000_7F7E, 4'd9},  // R9 end of memory
    '{1'b0, DT, 32'h0000_0000, 4'd9},
    '{1'b0, ST, 32'h0000_006D, 4'd8},
    '{1'b1, CM, 32'hC000_0001, 4'd10},
    '{1'b0, CM, 32'h8000_0001, 4'd10}, // R10 sw-ready dropped
    '{1'b1, CM, 32'h8000_0000, 4'd10},
    '{1'b0, CM, 32'h8000_0001, 4'd10}, // R10 write ignored while set
    '{1'b1, PS, 32'h0000_0007, 4'd3},
    '{1'b0, ST, 32'h0000_004D, 4'd3},  // R3 unmapped select
    '{1'b1, CM, 32'h0000_0000, 4'd10},
    '{1'b0, ST, 32'h0000_0003, 4'd10},
    '{1'b0, CM, 32'h0000_0001, 4'd10}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic        ld_we_i = 1'b0;
  logic [1:0]  ld_port_i = '0;
  logic [6:0]  ld_addr_i = '0;
  logic [7:0]  ld_data_i = '0;
  logic [3:0]  mon_present_i = 4'b1011;
  logic [3:0]  port_is_dp_i  = 4'b1000;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  edid_i2c_regs i_edid_i2c_regs (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int rq);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] rg, input logic [31:0] d,
                        output logic [31:0] q, output logic v);
    @(negedge clk_i);
    req_i = 1'b1; we_i = wr; addr_i = rg; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    q = rdata_o; v = rvalid_o;
  endtask

  int cyc_cnt = 0;
  always @(posedge clk_i) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 100000 && !done) begin
      n_bad++;
      $display("FAIL R1 actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    logic        v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 128; a++) begin
        @(negedge clk_i);
        ld_we_i = 1'b1; ld_port_i = 2'(p); ld_addr_i = 7'(a);
        ld_data_i = 8'(a + 64 * p);
      end
    end
    @(negedge clk_i);
    ld_we_i = 1'b0;

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].rg, VECS[i].val, q, v);
      if (!VECS[i].wr) check(q, VECS[i].val, int'(VECS[i].req));
    end

    // R1: read timing, valid pulses for one cycle
    access(1'b0, PS, 32'h0, q, v);
    check({31'd0, v}, 32'd1, 1);
    check(q, 32'h0000_0007, 1);
    @(negedge clk_i);
    check({31'd0, rvalid_o}, 32'd0, 1);

    // R1: reset mid-transfer clears everything
    access(1'b1, PS, 32'h1, q, v);
    access(1'b1, CM, 32'h0E0A_02A1, q, v);
    access(1'b0, DT, 32'h0, q, v);
    check(q, 32'h0504_0302, 7);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    access(1'b0, ST, 32'h0, q, v);
    check(q, 32'h0, 1);
    access(1'b0, CM, 32'h0, q, v);
    check(q, 32'h0, 1);
    access(1'b0, PS, 32'h0, q, v);
    check(q, 32'h0, 1);
    access(1'b0, DT, 32'h0, q, v);
    check(q, 32'h0, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule